// File: doc/BRIEF.md
# Watchdog Timer with Timed Access

This block is a free-running watchdog counter for a microcontroller-class chip. It counts clock cycles from zero up to one of four selectable periods. When it reaches the end of the period it raises a sticky time-out flag, wraps to zero and keeps counting. A sticky warning flag rises a fixed 512 clocks before each time-out. That warning drives an interrupt request through its own enable. When the reset function is armed, each time-out also produces a one-clock reset request for the rest of the chip.

Software must keep restarting the counter before it expires. The restart bit and the reset-enable bit are guarded by a timed-access key. A write of 0xAA to the key register, followed on the very next write by 0x55, opens a short window. Only inside that window do writes to the two guarded bits take effect. Errant code therefore cannot disarm or feed the watchdog by accident. The period select and the flag-clear bits are not guarded.

The register port has three registers, selected by `addr`:
- 0 is configuration. Bits 7:6 hold the period select.
- 1 is control. Bit 0 is restart, bit 1 is reset enable, bit 2 is the warning flag and bit 3 is the time-out flag.
- 2 is the key. It reads back the window state in bit 0.

Top module: `wdt_guard`

## Requirements
- R1: Reset clears the counter, both flags, the reset enable and the period select. After reset, reads of registers 0, 1 and 2 return 0, and `irq` and `wdt_rst` are low.
- R2: Bits 7:6 of register 0 hold the period select `s`, and it reads back unchanged. The time-out flag (register 1, bit 3) is first seen high exactly 2^(PERIOD_BASE_LOG2 + PERIOD_STEP_LOG2*s) clocks after the clock edge that performs a restart.
- R3: The warning flag (register 1, bit 2) rises exactly WARN_LEAD (512) clocks before the time-out flag rises.
- R4: `irq` is high exactly when the warning flag is set and `irq_en` is high. The reset enable does not affect it.
- R5: A time-out with the reset enable (register 1, bit 1) set drives `wdt_rst` high for exactly one clock, in the same cycle that the time-out flag rises. With the reset enable clear, `wdt_rst` stays low.
- R6: Writing 1 to register 1 bit 0 inside an open window zeroes the counter. Repeating this before expiry prevents any time-out and any reset request.
- R7: A write of 0xAA to register 2 arms the key. If the very next write is 0x55 to register 2, the window opens for the WINDOW_CLKS (3) clocks that follow that write, and register 2 bit 0 reads 1 while it is open. The window does not open if another write comes between the two key bytes, or if the first byte is not 0xAA.
- R8: A write to register 1 while the window is closed changes neither the reset enable nor the counter.
- R9: Both flags stay set until software writes 1 to register 1 bit 2 (warning) or bit 3 (time-out). These clear bits take effect whether or not the window is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 configuration, 1 control, 2 key |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register selected by `addr` |
| irq_en | input | 1 | Enable for the warning interrupt |
| irq | output | 1 | Warning interrupt request |
| wdt_rst | output | 1 | One-clock reset request on time-out |

## Verification
The bench builds the block with PERIOD_BASE_LOG2 = 10 and PERIOD_STEP_LOG2 = 1. This gives periods of 1024, 2048, 4096 and 8192 clocks. All four selects can then be swept to the exact cycle of each time-out, and the full 512-clock warning lead is still measured in every one of them. The window keeps its default length of 3. The bench sweeps the gap between the key and a guarded write from 0 to 4 idle cycles, which covers both sides of the window's closing edge. It also feeds the key with broken sequences.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_CTRL = 2'd1,
    REG_KEY  = 2'd2
  } wdt_reg_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int CTRL_RESTART = 0;
  localparam int CTRL_RST_EN  = 1;
  localparam int CTRL_WARN    = 2;
  localparam int CTRL_TOUT    = 3;
  localparam int CFG_SEL_LO   = 6;

endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate
  import wdt_pkg::*;
#(
  parameter int OPEN_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic       open
);

  localparam int WIN_W = $clog2(OPEN_CLKS + 1);

  logic             armed_q, armed_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             key_wr, fire;

  always_comb begin
    key_wr  = wr_en && (addr == REG_KEY);
    fire    = key_wr && armed_q && (wdata == KEY_SECOND);
    armed_d = armed_q;
    if (wr_en) armed_d = key_wr && (wdata == KEY_FIRST);
    win_d = win_q;
    if (fire)              win_d = WIN_W'(OPEN_CLKS);
    else if (win_q != '0)  win_d = win_q - WIN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else begin
      armed_q <= armed_d;
      win_q   <= win_d;
    end
  end

  assign open = (win_q != '0);

  // R7: window only opens on a completed key
  p_closed_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && !fire) |=> !open);
  // R7: a completed key opens the window
  p_key_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> open);
  // R7: the open window only shrinks
  p_window_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (open && !fire) |=> (win_q < $past(win_q)));

endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
  parameter int BASE  = 17,
  parameter int STEP  = 3,
  parameter int LEAD  = 512,
  parameter int CNT_W = BASE + 3 * STEP + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       warn_evt,
  output logic       tout_evt
);

  logic [CNT_W-1:0] last_tbl [4];
  logic [CNT_W-1:0] warn_tbl [4];
  logic [CNT_W-1:0] count_q, count_d;

  for (genvar g = 0; g < 4; g++) begin : g_period
    assign last_tbl[g] = CNT_W'((64'd1 << (BASE + STEP * g)) - 64'd1);
    assign warn_tbl[g] = CNT_W'((64'd1 << (BASE + STEP * g)) - 64'd1 - 64'(LEAD));
  end

  always_comb begin
    tout_evt = (count_q == last_tbl[sel]);
    warn_evt = (count_q == warn_tbl[sel]);
    if (restart || tout_evt) count_d = '0;
    else                     count_d = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  // R6: a restart zeroes the counter
  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count_q == '0));
  // R9: after a time-out the counter wraps and keeps running
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_evt && !restart) |=> (count_q == '0));

endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       open,
  input  logic       warn_evt,
  input  logic       tout_evt,
  input  logic       irq_en,
  output logic [1:0] sel,
  output logic       restart,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       wdt_rst
);

  logic [1:0] sel_q, sel_d;
  logic       rst_en_q, rst_en_d;
  logic       warn_q, warn_d;
  logic       tout_q, tout_d;
  logic       req_q, req_d;
  logic       cfg_wr, ctrl_wr, guarded_wr;
  logic       unused_wdata;

  assign unused_wdata = ^wdata[5:4];

  always_comb begin
    cfg_wr     = wr_en && (addr == REG_CFG);
    ctrl_wr    = wr_en && (addr == REG_CTRL);
    guarded_wr = ctrl_wr && open;
    restart    = guarded_wr && wdata[CTRL_RESTART];
    sel_d      = cfg_wr ? wdata[CFG_SEL_LO+1:CFG_SEL_LO] : sel_q;
    rst_en_d   = guarded_wr ? wdata[CTRL_RST_EN] : rst_en_q;
    warn_d     = warn_evt | (warn_q & ~(ctrl_wr & wdata[CTRL_WARN]));
    tout_d     = tout_evt | (tout_q & ~(ctrl_wr & wdata[CTRL_TOUT]));
    req_d      = tout_evt & rst_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      rst_en_q <= 1'b0;
      warn_q   <= 1'b0;
      tout_q   <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      sel_q    <= sel_d;
      rst_en_q <= rst_en_d;
      warn_q   <= warn_d;
      tout_q   <= tout_d;
      req_q    <= req_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_CFG:  rdata[CFG_SEL_LO+1:CFG_SEL_LO] = sel_q;
      REG_CTRL: begin
        rdata[CTRL_RST_EN] = rst_en_q;
        rdata[CTRL_WARN]   = warn_q;
        rdata[CTRL_TOUT]   = tout_q;
      end
      REG_KEY:  rdata[0] = open;
      default:  rdata = '0;
    endcase
  end

  assign sel     = sel_q;
  assign irq     = warn_q & irq_en;
  assign wdt_rst = req_q;

  // R8: a control write with the window closed leaves the reset enable alone
  p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !open) |=> (rst_en_q == $past(rst_en_q)));
  // R5: the reset request lasts one clock
  p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  // R5: a reset request comes only with a raised time-out flag
  p_pulse_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> tout_q);
  // R9: the warning flag stays set until it is cleared
  p_warn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_q && !(ctrl_wr && wdata[CTRL_WARN])) |=> warn_q);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int PERIOD_BASE_LOG2 = 17,
  parameter int PERIOD_STEP_LOG2 = 3,
  parameter int WARN_LEAD        = 512,
  parameter int WINDOW_CLKS      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       irq_en,
  output logic       irq,
  output logic       wdt_rst
);

  localparam int CNT_W = PERIOD_BASE_LOG2 + 3 * PERIOD_STEP_LOG2 + 1;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       open, restart, warn_evt, tout_evt;
  logic [1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  wdt_key_gate #(.OPEN_CLKS(WINDOW_CLKS)) u_key (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .open  (open)
  );

  wdt_count_core #(
    .BASE  (PERIOD_BASE_LOG2),
    .STEP  (PERIOD_STEP_LOG2),
    .LEAD  (WARN_LEAD),
    .CNT_W (CNT_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .restart  (restart),
    .sel      (sel),
    .warn_evt (warn_evt),
    .tout_evt (tout_evt)
  );

  wdt_ctrl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .open     (open),
    .warn_evt (warn_evt),
    .tout_evt (tout_evt),
    .irq_en   (irq_en),
    .sel      (sel),
    .restart  (restart),
    .rdata    (rdata),
    .irq      (irq),
    .wdt_rst  (wdt_rst)
  );

  // R4: no interrupt request without its enable
  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> irq_en);
  // R3: warning and time-out events never coincide
  p_events_apart_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(warn_evt && tout_evt));

endmodule

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;

  localparam int BASE = 10;
  localparam int STEP = 1;
  localparam int LEAD = 512;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq_en;
  logic       irq;
  logic       wdt_rst;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_guard #(
    .PERIOD_BASE_LOG2 (BASE),
    .PERIOD_STEP_LOG2 (STEP),
    .WARN_LEAD        (LEAD),
    .WINDOW_CLKS      (3)
  ) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq_en  (irq_en),
    .irq     (irq),
    .wdt_rst (wdt_rst)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write happens at the next rising edge
  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic unlock();
    write_reg(2'd2, 8'hAA);
    write_reg(2'd2, 8'h55);
  endtask

  // watch from restart time e0 until the time-out flag is seen
  task automatic measure(input longint e0, input int limit,
                         output longint warn_dt, output longint tout_dt,
                         output longint rst_dt, output logic rst_next);
    logic [7:0] v;
    warn_dt = -1; tout_dt = -1; rst_dt = -1; rst_next = 1'b0;
    for (int n = 0; n < limit && tout_dt < 0; n++) begin
      @(negedge clk);
      read_reg(2'd1, v);
      if (v[2] && warn_dt < 0) warn_dt = cyc - e0;
      if (v[3]) tout_dt = cyc - e0;
      if (wdt_rst && rst_dt < 0) rst_dt = cyc - e0;
    end
    @(negedge clk);
    rst_next = wdt_rst;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    longint e0, wdt_w, wdt_t, wdt_r;
    logic   rn;
    int     bad;

    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00; irq_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    read_reg(2'd0, v); chk("R1 cfg after reset", v, 0);
    read_reg(2'd1, v); chk("R1 ctrl after reset", v, 0);
    read_reg(2'd2, v); chk("R1 key after reset", v, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 wdt_rst after reset", wdt_rst, 0);
    @(negedge clk);

    // R2 R3: sweep all four periods, reset disabled
    for (int s = 0; s < 4; s++) begin
      write_reg(2'd0, 8'(s << 6));
      read_reg(2'd0, v);
      chk("R2 select readback", v, s << 6);
      @(negedge clk);
      unlock();
      write_reg(2'd1, 8'h0D);
      e0 = cyc;
      measure(e0, 20000, wdt_w, wdt_t, wdt_r, rn);
      chk("R2 time-out cycle", wdt_t, longint'(1) << (BASE + STEP * s));
      chk("R3 warning lead", wdt_t - wdt_w, LEAD);
      chk("R5 no pulse while disabled", wdt_r, -1);
    end

    // R5: reset enabled, select 0
    write_reg(2'd0, 8'h00);
    unlock();
    write_reg(2'd1, 8'h0F);
    e0 = cyc;
    measure(e0, 5000, wdt_w, wdt_t, wdt_r, rn);
    chk("R5 pulse cycle", wdt_r, 1024);
    chk("R5 pulse with flag", wdt_t, 1024);
    chk("R5 pulse one clock", rn, 0);

    // R9: unguarded flag clear keeps the reset enable
    write_reg(2'd1, 8'h0C);
    read_reg(2'd1, v);
    chk("R9 flags cleared, enable kept", v, 8'h02);
    @(negedge clk);

    // R6: repeated restarts hold off the reset
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      unlock();
      write_reg(2'd1, 8'h0B);
      for (int k = 0; k < 700; k++) begin
        @(negedge clk);
        read_reg(2'd1, v);
        if (wdt_rst || v[3]) bad++;
      end
      @(negedge clk);
    end
    chk("R6 restarts prevent time-out", bad, 0);

    // R8: guarded restart written with the window closed is ignored
    unlock();
    write_reg(2'd1, 8'h0F);
    e0 = cyc;
    repeat (300) @(negedge clk);
    write_reg(2'd1, 8'h01);
    measure(e0, 5000, wdt_w, wdt_t, wdt_r, rn);
    chk("R8 blocked restart, time-out unchanged", wdt_t, 1024);
    chk("R8 blocked write kept enable", wdt_r, 1024);

    // R7: window length sweep
    for (int d = 0; d < 5; d++) begin
      unlock();
      write_reg(2'd1, 8'h00);
      unlock();
      read_reg(2'd2, v);
      chk("R7 window open after key", v, 1);
      if (d > 0) repeat (d) @(negedge clk);
      else @(negedge clk);
      if (d == 0) begin
        // re-run with zero gap: open again and write at once
        unlock();
      end
      write_reg(2'd1, 8'h02);
      read_reg(2'd1, v);
      chk("R7 guarded write inside window", v[1], (d <= 2) ? 1 : 0);
      @(negedge clk);
    end

    // R7 R8: broken key sequences
    unlock(); write_reg(2'd1, 8'h00);
    write_reg(2'd2, 8'hAA);
    write_reg(2'd0, 8'h00);
    write_reg(2'd2, 8'h55);
    read_reg(2'd2, v);
    chk("R7 interrupted key stays closed", v, 0);
    @(negedge clk);
    write_reg(2'd1, 8'h02);
    read_reg(2'd1, v);
    chk("R8 enable unchanged without key", v[1], 0);
    @(negedge clk);
    write_reg(2'd2, 8'h12);
    write_reg(2'd2, 8'h55);
    read_reg(2'd2, v);
    chk("R7 wrong first byte stays closed", v, 0);
    @(negedge clk);
    write_reg(2'd2, 8'hAA);
    unlock();
    read_reg(2'd2, v);
    chk("R7 repeated first byte opens", v, 1);
    @(negedge clk);

    // R4: interrupt gating
    irq_en = 1'b0;
    unlock();
    write_reg(2'd1, 8'h0D);
    e0 = cyc;
    bad = 1;
    for (int n = 0; n < 2000 && bad != 0; n++) begin
      @(negedge clk);
      read_reg(2'd1, v);
      if (v[2]) bad = 0;
    end
    chk("R3 warning after restart", cyc - e0, 1024 - LEAD);
    chk("R4 irq masked", irq, 0);
    irq_en = 1'b1;
    #1;
    chk("R4 irq enabled", irq, 1);
    @(negedge clk);
    write_reg(2'd1, 8'h04);
    read_reg(2'd1, v);
    chk("R9 warning cleared", v[2], 0);
    chk("R4 irq drops with flag", irq, 0);
    @(negedge clk);
    irq_en = 1'b0;

    // R1: reset in mid-run clears enable and select
    write_reg(2'd0, 8'h80);
    unlock();
    write_reg(2'd1, 8'h0E);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_reg(2'd0, v); chk("R1 select cleared by reset", v, 0);
    read_reg(2'd1, v); chk("R1 ctrl cleared by reset", v, 0);
    chk("R1 no pulse after reset", wdt_rst, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule